// File: doc/BRIEF.md
# Snapshot Priority Arbiter

This block gives one shared output port to one of several requesting channels (three by default). When the port is idle and at least one request line is high, the arbiter raises its lock signal. In the same clock edge it freezes the current request pattern, and the priority data that goes with it, into a snapshot register. A per-channel admission stage decides which requests make it into the snapshot: only requests present before the lock rises are admitted. The winner is chosen from the frozen snapshot alone, so a request that arrives while a round is being evaluated cannot change that round's outcome.

Each channel supplies a 2-bit priority value. A mode input selects whether these values are used or whether priority comes from channel position alone. The winning channel's grant is one-hot and stays asserted until the release input is pulsed. Release ends the round: grant and lock both drop on the next edge. On the edge after that, a fresh snapshot is taken from whatever requests are pending. Requests are level signals. A request that was left out of a snapshot therefore stays pending and competes in the next round. The asynchronous mutual-exclusion behaviour is modelled on a single clock.

Top module: `lpa_arbiter`

## Requirements
- R1: While rst_n is low, and on the first edge after it is released, grant_o is all zeros and lock_o is low, whatever the request inputs are.
- R2: When lock_o is low and any req_i bit is high at a clock edge, lock_o is high after that edge. The req_i pattern, prio_i and dyn_prio_i are captured at that same edge.
- R3: grant_o never has more than one bit set.
- R4: On the edge after lock_o rises, exactly one grant bit is set. It belongs to the captured requester with the largest priority value. Channel i's priority is prio_i[2*i+1:2*i], and a larger value means higher priority.
- R5: Among captured requesters that share the largest priority value, the lowest channel index wins.
- R6: If dyn_prio_i was 0 at capture, the priority values are ignored and the lowest-indexed captured requester wins.
- R7: A request that rises after lock_o is already high is left out of the current round. It does not affect the grant. If it stays high, it is served in a later round.
- R8: A grant is held unchanged while release_i is low. When release_i is high during a grant, grant_o goes to zero and lock_o goes low on the next edge.
- R9: On the edge after a release, if requests are pending, lock_o rises again. On the edge after that, the grant goes to the highest-priority request that accumulated while the port was busy.
- R10: A release_i pulse while no grant is held has no effect on lock_o, on grant_o, or on the timing of the next round.
- R11: Changes to prio_i or dyn_prio_i after the snapshot edge do not change that round's winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | N_CH (3) | Level request, one bit per channel |
| prio_i | input | N_CH*PRIO_W (6) | Per-channel priority, channel i at bits [2*i+1:2*i] |
| dyn_prio_i | input | 1 | 1: use prio_i; 0: priority by channel index |
| release_i | input | 1 | Current holder frees the port |
| lock_o | output | 1 | A round is in progress (snapshot frozen) |
| grant_o | output | N_CH (3) | One-hot grant to the winning channel |

## Verification
A wrong snapshot or a stale stored priority shows up as the wrong grant bit. It appears exactly two edges after the request that opened the round, so every round is checked at that cycle against a winner the bench computes from the pattern it drove. A control sequencer stuck in the wrong state shows up as lock_o or grant_o failing to rise or fall on the edge the requirements name. Examples are a missing gap cycle after release, or a grant that drops without a release. Late-arrival and accumulation scenarios drive a higher-priority request into the busy window. This catches an admission stage that leaks into the frozen pattern.

// File: rtl/lpa_pkg.sv
// Package: shared types for the snapshot priority arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package lpa_pkg;

    // Round sequencing: idle, evaluating the frozen snapshot, holding a grant.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_HOLD = 2'd2
    } arb_state_t;

endpackage

// File: rtl/lpa_admit.sv
// Module: lpa_admit
// Behavioural stand-in for the per-channel mutual-exclusion element that
// sits between a request and the lock. A request is admitted only if it
// is present while the lock is still low; once the lock has won, the
// request is excluded from the current snapshot.
// Assumes: single-clock abstraction; both inputs come from registered or
// synchronous sources.
module lpa_admit (
    input  logic req_i,
    input  logic lock_i,
    output logic admit_o
);

    // Request wins the mutual exclusion only when the lock has not.
    always_comb begin
        admit_o = req_i & ~lock_i;
    end

endmodule

// File: rtl/lpa_pick.sv
// Module: lpa_pick
// Combinational priority evaluation over a frozen candidate set.
// The largest priority value wins; ties go to the lowest index.
// Assumes: cand_i and prio_i are stable register outputs during evaluation.
module lpa_pick #(
    parameter int N_CH   = 3,
    parameter int PRIO_W = 2
) (
    input  logic [N_CH-1:0]        cand_i,
    input  logic [N_CH*PRIO_W-1:0] prio_i,
    output logic [N_CH-1:0]        win_o
);

    // Linear scan; a strict comparison keeps the earliest index on ties.
    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best;
        win_o = '0;
        found = 1'b0;
        best  = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                win_o    = '0;
                win_o[i] = 1'b1;
                best     = prio_i[i*PRIO_W +: PRIO_W];
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpa_ctrl.sv
// Module: lpa_ctrl
// Round sequencer: opens a round (lock) when any request is admitted,
// spends one cycle evaluating the snapshot, then holds until release.
// Assumes: release_i is only meaningful in the hold state.
module lpa_ctrl
    import lpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_admit_i,
    input  logic       release_i,
    output arb_state_t state_o,
    output logic       load_snap_o,
    output logic       load_grant_o,
    output logic       clear_o
);

    arb_state_t state_q, state_d;

    // Next-state and strobe decoding.
    always_comb begin
        state_d      = state_q;
        load_snap_o  = 1'b0;
        load_grant_o = 1'b0;
        clear_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: if (any_admit_i) begin
                load_snap_o = 1'b1;
                state_d     = ST_EVAL;
            end
            ST_EVAL: begin
                load_grant_o = 1'b1;
                state_d      = ST_HOLD;
            end
            ST_HOLD: if (release_i) begin
                clear_o = 1'b1;
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/lpa_arbiter.sv
// Module: lpa_arbiter (top)
// Snapshot priority arbiter: freezes admitted requests and their
// priorities when the lock rises, picks one winner from the frozen set,
// and holds the one-hot grant until release.
// Assumes: requests are level signals held until served; prio_i packs
// channel i at [i*PRIO_W +: PRIO_W], larger value = higher priority.
module lpa_arbiter
    import lpa_pkg::*;
#(
    parameter int N_CH   = 3,
    parameter int PRIO_W = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH-1:0]        req_i,
    input  logic [N_CH*PRIO_W-1:0] prio_i,
    input  logic                   dyn_prio_i,
    input  logic                   release_i,
    output logic                   lock_o,
    output logic [N_CH-1:0]        grant_o
);

    localparam int PV_W = N_CH * PRIO_W;

    arb_state_t      state;
    logic            load_snap, load_grant, clear;
    logic [N_CH-1:0] admit;
    logic [N_CH-1:0] snap_q;
    logic [PV_W-1:0] prio_q;
    logic            dyn_q;
    logic [PV_W-1:0] prio_eff;
    logic [N_CH-1:0] win;
    logic [N_CH-1:0] grant_q;

    assign lock_o = (state != ST_IDLE);

    // One admission element per channel, plus the effective priority slice.
    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        lpa_admit u_admit (
            .req_i   (req_i[g]),
            .lock_i  (lock_o),
            .admit_o (admit[g])
        );
        assign prio_eff[g*PRIO_W +: PRIO_W] =
            dyn_q ? prio_q[g*PRIO_W +: PRIO_W] : {PRIO_W{1'b0}};
    end

    lpa_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_admit_i  (|admit),
        .release_i    (release_i),
        .state_o      (state),
        .load_snap_o  (load_snap),
        .load_grant_o (load_grant),
        .clear_o      (clear)
    );

    lpa_pick #(.N_CH(N_CH), .PRIO_W(PRIO_W)) u_pick (
        .cand_i (snap_q),
        .prio_i (prio_eff),
        .win_o  (win)
    );

    // Snapshot registers: request pattern, priorities and mode frozen at lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            prio_q <= '0;
            dyn_q  <= 1'b0;
        end else if (load_snap) begin
            snap_q <= admit;
            prio_q <= prio_i;
            dyn_q  <= dyn_prio_i;
        end else if (clear) begin
            snap_q <= '0;
        end
    end

    // Grant register: loaded once per round, cleared on release.
    always_ff @(posedge clk) begin
        if (!rst_n)          grant_q <= '0;
        else if (load_grant) grant_q <= win;
        else if (clear)      grant_q <= '0;
    end

    assign grant_o = grant_q;

endmodule

// File: rtl/lpa_arbiter_chk.sv
// Module: lpa_arbiter_chk
// Port-level protocol checks for lpa_arbiter, attached by bind.
module lpa_arbiter_chk #(
    parameter int N_CH = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_CH-1:0] req_i,
    input logic            release_i,
    input logic            lock_o,
    input logic [N_CH-1:0] grant_o
);

    // R3
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R2
    lock_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_o && (|req_i)) |=> lock_o);

    // R4
    grant_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |=> $onehot(grant_o));

    // R4
    grant_within_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> lock_o);

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && !release_i) |=> (grant_o == $past(grant_o)));

    // R8
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant_o) && release_i) |=> ((grant_o == '0) && !lock_o));

endmodule

bind lpa_arbiter lpa_arbiter_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .release_i (release_i),
    .lock_o    (lock_o),
    .grant_o   (grant_o)
);

// File: tb/lpa_arbiter_test.sv
// Bench for lpa_arbiter: exhaustive sweep of request patterns and
// priority vectors in both modes, plus directed late-arrival,
// accumulation, stray-release and priority-change scenarios.
module lpa_arbiter_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] req;
    logic [5:0] prio;
    logic       dyn;
    logic       rel;
    logic       lock;
    logic [2:0] grant;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;

    lpa_arbiter uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .prio_i     (prio),
        .dyn_prio_i (dyn),
        .release_i  (rel),
        .lock_o     (lock),
        .grant_o    (grant)
    );

    // Compare one value and report a failure.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected winner: largest value, ties to lowest index; index order in static mode.
    function automatic logic [2:0] exp_win(input logic [2:0] r, input logic [5:0] p, input logic d);
        int best = -1;
        int bi   = -1;
        for (int i = 0; i < 3; i++) begin
            int v = d ? int'(p[2*i +: 2]) : 0;
            if (r[i] && v > best) begin
                best = v;
                bi   = i;
            end
        end
        return (bi < 0) ? 3'b000 : 3'(1 << bi);
    endfunction

    // One full round from idle: open, evaluate, hold, release.
    task automatic round(input logic [2:0] r, input logic [5:0] p, input logic d);
        logic [2:0] w = exp_win(r, p, d);
        @(negedge clk); req = r; prio = p; dyn = d;
        @(negedge clk);
        chk("R2 lock", int'(lock), 1);
        chk("R2 no early grant", int'(grant), 0);
        @(negedge clk);
        chk(d ? "R4 R5 winner" : "R6 static winner", int'(grant), int'(w));
        @(negedge clk);
        chk("R8 held", int'(grant), int'(w));
        rel = 1'b1; req = 3'b000;
        @(negedge clk);
        chk("R8 cleared grant", int'(grant), 0);
        chk("R8 cleared lock", int'(lock), 0);
        rel = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; req = 3'b111; prio = '0; dyn = 1'b1; rel = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset dominates pending requests
        chk("R1 grant in reset", int'(grant), 0);
        chk("R1 lock in reset", int'(lock), 0);
        req = 3'b000;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant after reset", int'(grant), 0);
        chk("R1 lock after reset", int'(lock), 0);

        // R4 R5 R6: every pattern and priority vector, both modes
        for (int r = 1; r < 8; r++) begin
            for (int p = 0; p < 64; p++) round(3'(r), 6'(p), 1'b1);
            round(3'(r), 6'b00_01_11, 1'b0);
            round(3'(r), 6'b11_10_00, 1'b0);
        end

        // R7: late high-priority request excluded, then served
        @(negedge clk); req = 3'b001; prio = 6'b11_00_00; dyn = 1'b1;
        @(negedge clk); chk("R7 lock", int'(lock), 1);
        req = 3'b101;
        @(negedge clk); chk("R7 late excluded", int'(grant), 3'b001);
        rel = 1'b1; req = 3'b100;
        @(negedge clk); rel = 1'b0;
        chk("R9 gap grant", int'(grant), 0);
        chk("R9 gap lock", int'(lock), 0);
        @(negedge clk); chk("R9 relock", int'(lock), 1);
        @(negedge clk); chk("R7 late served", int'(grant), 3'b100);
        rel = 1'b1; req = 3'b000;
        @(negedge clk); rel = 1'b0;

        // R9: accumulation during busy; highest wins next round
        @(negedge clk); req = 3'b001; prio = 6'b11_01_00;
        @(negedge clk); req = 3'b011;
        @(negedge clk); chk("R9 first holder", int'(grant), 3'b001);
        req = 3'b111;
        @(negedge clk); chk("R8 held with pending", int'(grant), 3'b001);
        rel = 1'b1; req = 3'b110;
        @(negedge clk); rel = 1'b0;
        @(negedge clk); chk("R9 relock after busy", int'(lock), 1);
        @(negedge clk); chk("R9 accumulated winner", int'(grant), 3'b100);
        rel = 1'b1; req = 3'b010;
        @(negedge clk); rel = 1'b0;
        @(negedge clk);
        @(negedge clk); chk("R9 remaining served", int'(grant), 3'b010);
        rel = 1'b1; req = 3'b000;
        @(negedge clk); rel = 1'b0;

        // R10: stray release while idle
        @(negedge clk); rel = 1'b1;
        @(negedge clk); rel = 1'b0;
        chk("R10 lock unchanged", int'(lock), 0);
        chk("R10 grant unchanged", int'(grant), 0);
        round(3'b110, 6'b10_10_00, 1'b1);

        // R10: stray release during evaluation cycle
        @(negedge clk); req = 3'b010; prio = 6'b00_00_00;
        @(negedge clk); rel = 1'b1;
        @(negedge clk); rel = 1'b0;
        chk("R10 grant despite early release", int'(grant), 3'b010);
        @(negedge clk); chk("R10 still held", int'(grant), 3'b010);
        rel = 1'b1; req = 3'b000;
        @(negedge clk); rel = 1'b0;

        // R11: priority and mode changed after snapshot edge
        @(negedge clk); req = 3'b101; prio = 6'b11_00_01; dyn = 1'b1;
        @(negedge clk); prio = 6'b00_00_11; dyn = 1'b0;
        @(negedge clk); chk("R11 frozen priority", int'(grant), 3'b100);
        rel = 1'b1; req = 3'b000;
        @(negedge clk); rel = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule